// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block sits on the host side of a 14-bit sampling converter that has a parallel output bus. It generates every control pin the converter needs: the start strobe, the chip select, the read strobe, an optional conversion clock and the shutdown request. It watches the converter's active-low end-of-conversion flag and captures the result word. All timing limits are parameters counted in system clock cycles. These limits are the power-up wake delay, the priming period, the acquisition window, the read access window, the bus quiet gap and the conversion timeout.

A conversion begins when `start_req` is seen in the idle state. The start strobe is driven low for the acquisition window, and the converter samples its input when the strobe rises. There are two conversion clock modes. In internal-clock mode the sequencer waits for the end-of-conversion flag. In external-clock mode it also emits a burst of conversion clock edges and waits until that burst completes. Next, chip select and read go low together for the read window, and the word is captured on the last cycle of that window. The start strobe stays high for the whole read. The captured word is turned into a 16-bit signed sample. An offset-binary code has its midscale removed, and a two's-complement code is sign-extended. The sample is presented with a one-cycle valid pulse.

After reset, and after each exit from shutdown, the sequencer waits out the wake delay. It then primes the converter with the start strobe held high. In external-clock mode priming is a train of clock pulses; in internal-clock mode it is a fixed hold time. Only after priming does it accept conversions.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `adc_convst`, `adc_cs_n` and `adc_rd_n` are high, `adc_shdn`, `sample_valid` and `timeout_err` are low, and `start_req` is ignored until the wake delay and priming have completed.
- R2: Priming holds `adc_convst` high. In external-clock mode it issues exactly PRIME_EDGES rising edges on `adc_clk`. In internal-clock mode it lasts PRIME_INT_CYC cycles and issues no clock edge.
- R3: An accepted `start_req` drives `adc_convst` low for exactly ACQ_CYC cycles.
- R4: `adc_convst` stays high from its rising edge until the read strobe has returned high.
- R5: In external-clock mode (`ext_clk_mode`=1), exactly CONV_EDGES rising edges appear on `adc_clk` per conversion, each high phase lasting CLK_HALF cycles. In internal-clock mode `adc_clk` stays low.
- R6: `adc_cs_n` and `adc_rd_n` fall and rise together, stay low for exactly RD_CYC cycles, and the data word is captured on the last cycle of that window.
- R7: At least QUIET_CYC+1 cycles separate the rise of `adc_rd_n` from the next fall of `adc_convst`.
- R8: With `bipolar`=0 the code is offset binary, so `sample` = code − 8192 (0x2000→0, 0x3FFF→8191, 0x0000→−8192).
- R9: With `bipolar`=1 the code is 14-bit two's complement, sign-extended to 16 bits (0x2000→−8192, 0x3FFF→−1, 0x1FFF→8191, 0x0001→1).
- R10: Each completed read produces one `sample_valid` pulse of exactly one cycle.
- R11: If `adc_eoc_n` is not seen low within TIMEOUT_CYC cycles of the start strobe rising, `timeout_err` pulses for one cycle, no read is made, and the sequencer returns to idle ready for a new request.
- R12: `shutdown_req` seen in idle raises `adc_shdn` and blocks conversions. Its release lowers `adc_shdn` and repeats the wake delay and priming before any conversion.
- R13: A `start_req` that arrives while a conversion is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_mode | input | 1 | 1: sequencer drives the conversion clock; 0: converter clocks itself |
| bipolar | input | 1 | 1: two's-complement codes; 0: offset-binary codes |
| start_req | input | 1 | Request one conversion (taken in idle only) |
| shutdown_req | input | 1 | Level request to power the converter down |
| adc_eoc_n | input | 1 | Converter end-of-conversion flag, active low, asynchronous |
| adc_data | input | 14 | Converter parallel result bus |
| adc_convst | output | 1 | Start strobe: low acquires, rising edge samples |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_clk | output | 1 | Generated conversion clock (external-clock mode) |
| adc_shdn | output | 1 | Shutdown request to the converter |
| sample | output | 16 | Signed result |
| sample_valid | output | 1 | One-cycle strobe marking a new `sample` |
| timeout_err | output | 1 | One-cycle pulse on a missing end-of-conversion |

## Verification
The assertions assume several things about the inputs. The end-of-conversion flag goes low only while a conversion is pending. `ext_clk_mode` and `bipolar` change only under reset or between conversions. Every parameter is at least one cycle, and TIMEOUT_CYC is longer than the clock burst. The bench meets these assumptions in three ways. Its converter model pulses the flag only after a start-strobe rise, with a fixed internal delay or on the seventeenth clock edge. It switches the clock mode only while reset is asserted. Its timeout case withholds the flag entirely rather than firing it late.

// File: rtl/adc_seq_pkg.sv
// Shared types and helpers for the ADC conversion sequencer.
// Assumes: nothing beyond IEEE 1800-2017 integer semantics.
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_WAKE  = 3'd0,
        ST_PRIME = 3'd1,
        ST_IDLE  = 3'd2,
        ST_ACQ   = 3'd3,
        ST_CONV  = 3'd4,
        ST_READ  = 3'd5,
        ST_QUIET = 3'd6,
        ST_SHDN  = 3'd7
    } seq_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_wait_timer.sv
// Down-counter shared by all timed sequencer states.
// A load of N-1 makes zero rise N cycles later; it holds at zero.
// Assumes: load_val fits in W bits.
module adc_wait_timer #(
    parameter int W    = 8,
    parameter int INIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // count down towards zero, reload on request
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= W'(INIT);
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/adc_cnv_clkgen.sv
// Burst generator for the converter clock: on go it emits exactly
// `edges` rising edges, each phase HALF_CYC system cycles long, then
// parks low. Assumes go only when done is high or to restart a burst.
module adc_cnv_clkgen #(
    parameter int HALF_CYC = 10,
    parameter int EDGE_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [EDGE_W-1:0] edges,
    output logic              cnv_clk,
    output logic              done
);
    localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic              active_q;
    logic              clk_q;
    logic [HW-1:0]     phase_q;
    logic [EDGE_W-1:0] rem_q;

    // phase counter, clock toggle and remaining-edge bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            clk_q    <= 1'b0;
            phase_q  <= '0;
            rem_q    <= '0;
        end else if (go) begin
            active_q <= 1'b1;
            clk_q    <= 1'b0;
            phase_q  <= '0;
            rem_q    <= edges;
        end else if (active_q) begin
            if (phase_q == HW'(HALF_CYC - 1)) begin
                phase_q <= '0;
                if (!clk_q) begin
                    clk_q <= 1'b1;
                    rem_q <= rem_q - 1'b1;
                end else begin
                    clk_q <= 1'b0;
                    if (rem_q == '0) active_q <= 1'b0;
                end
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    assign cnv_clk = clk_q;
    assign done    = !active_q;

    AST_RISE_WITHIN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_q) |-> ($past(rem_q) != '0)); // R5

    AST_PARKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !$past(go)) |-> !clk_q); // R5

endmodule

// File: rtl/adc_code_fmt.sv
// Captures the converter word and converts it to a signed sample in the
// same flop stage: offset binary loses its midscale, two's complement
// is sign-extended. Assumes OUT_W > CODE_W.
module adc_code_fmt #(
    parameter int CODE_W = 14,
    parameter int OUT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              bipolar,
    input  logic [CODE_W-1:0] code,
    output logic [OUT_W-1:0]  sample,
    output logic              valid
);
    localparam int EXT = OUT_W - CODE_W + 1;

    logic             sign_bit;
    logic [OUT_W-1:0] fmt_w;

    // choose the sign: inverted MSB for offset binary, MSB as is otherwise
    always_comb begin
        sign_bit = bipolar ? code[CODE_W-1] : ~code[CODE_W-1];
        fmt_w    = {{EXT{sign_bit}}, code[CODE_W-2:0]};
    end

    // result register and its one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= load;
            if (load) sample <= fmt_w;
        end
    end

    AST_LOAD_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> valid); // R10

    AST_SAMPLE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((&sample[OUT_W-1:CODE_W-1]) || !(|sample[OUT_W-1:CODE_W-1]))); // R8

endmodule

// File: rtl/adc_seq_ctrl.sv
// Host-side sequencer for a parallel-output sampling converter.
// Runs wake/prime, acquisition, conversion (internal or generated
// clock), read and quiet phases, all timed in system clock cycles.
// Assumes: every *_CYC parameter >= 1, TIMEOUT_CYC longer than a clock
// burst, ext_clk_mode and bipolar stable while a conversion runs.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CODE_W        = 14,
    parameter int OUT_W         = 16,
    parameter int WAKE_CYC      = 200000,
    parameter int PRIME_INT_CYC = 400,
    parameter int PRIME_EDGES   = 20,
    parameter int CONV_EDGES    = 17,
    parameter int CLK_HALF      = 10,
    parameter int ACQ_CYC       = 40,
    parameter int RD_CYC        = 6,
    parameter int QUIET_CYC     = 10,
    parameter int TIMEOUT_CYC   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk_mode,
    input  logic              bipolar,
    input  logic              start_req,
    input  logic              shutdown_req,
    input  logic              adc_eoc_n,
    input  logic [CODE_W-1:0] adc_data,
    output logic              adc_convst,
    output logic              adc_cs_n,
    output logic              adc_rd_n,
    output logic              adc_clk,
    output logic              adc_shdn,
    output logic [OUT_W-1:0]  sample,
    output logic              sample_valid,
    output logic              timeout_err
);
    localparam int T_MAX  = imax(imax(imax(WAKE_CYC, PRIME_INT_CYC), imax(ACQ_CYC, RD_CYC)),
                                 imax(QUIET_CYC, TIMEOUT_CYC));
    localparam int TW     = $clog2(T_MAX + 1);
    localparam int EDGE_W = $clog2(imax(PRIME_EDGES, CONV_EDGES) + 1);

    seq_state_t        st_q, st_nxt;
    logic              tmr_ld, tmr_zero;
    logic [TW-1:0]     tmr_val;
    logic              burst_go, burst_done;
    logic [EDGE_W-1:0] burst_edges;
    logic              cap, err_set;
    logic [1:0]        eoc_sync_q;
    logic              eoc_seen_q, eoc_hit;
    logic              convst_q, rd_q, cs_q, shdn_q, err_q;

    // bring the converter's asynchronous flag into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) eoc_sync_q <= 2'b11;
        else        eoc_sync_q <= {eoc_sync_q[0], adc_eoc_n};
    end

    // remember a flag pulse that ends before the clock burst does
    always_ff @(posedge clk) begin
        if (!rst_n || st_q != ST_CONV) eoc_seen_q <= 1'b0;
        else if (!eoc_sync_q[1])       eoc_seen_q <= 1'b1;
    end

    assign eoc_hit = eoc_seen_q || !eoc_sync_q[1];

    // next-state, timer reload and burst launch decisions
    always_comb begin
        st_nxt      = st_q;
        tmr_ld      = 1'b0;
        tmr_val     = '0;
        burst_go    = 1'b0;
        burst_edges = '0;
        cap         = 1'b0;
        err_set     = 1'b0;
        case (st_q)
            ST_WAKE: if (tmr_zero) begin
                st_nxt = ST_PRIME;
                if (ext_clk_mode) begin
                    burst_go    = 1'b1;
                    burst_edges = EDGE_W'(PRIME_EDGES);
                end else begin
                    tmr_ld  = 1'b1;
                    tmr_val = TW'(PRIME_INT_CYC - 1);
                end
            end
            ST_PRIME: if (ext_clk_mode ? burst_done : tmr_zero) st_nxt = ST_IDLE;
            ST_IDLE: begin
                if (shutdown_req) begin
                    st_nxt = ST_SHDN;
                end else if (start_req) begin
                    st_nxt  = ST_ACQ;
                    tmr_ld  = 1'b1;
                    tmr_val = TW'(ACQ_CYC - 1);
                end
            end
            ST_ACQ: if (tmr_zero) begin
                st_nxt  = ST_CONV;
                tmr_ld  = 1'b1;
                tmr_val = TW'(TIMEOUT_CYC - 1);
                if (ext_clk_mode) begin
                    burst_go    = 1'b1;
                    burst_edges = EDGE_W'(CONV_EDGES);
                end
            end
            ST_CONV: begin
                if (eoc_hit && (!ext_clk_mode || burst_done)) begin
                    st_nxt  = ST_READ;
                    tmr_ld  = 1'b1;
                    tmr_val = TW'(RD_CYC - 1);
                end else if (tmr_zero) begin
                    st_nxt  = ST_IDLE;
                    err_set = 1'b1;
                end
            end
            ST_READ: if (tmr_zero) begin
                st_nxt  = ST_QUIET;
                cap     = 1'b1;
                tmr_ld  = 1'b1;
                tmr_val = TW'(QUIET_CYC - 1);
            end
            ST_QUIET: if (tmr_zero) st_nxt = ST_IDLE;
            ST_SHDN: if (!shutdown_req) begin
                st_nxt  = ST_WAKE;
                tmr_ld  = 1'b1;
                tmr_val = TW'(WAKE_CYC - 1);
            end
            default: st_nxt = ST_WAKE;
        endcase
    end

    // state register plus pin registers decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_WAKE;
            convst_q <= 1'b1;
            rd_q     <= 1'b1;
            cs_q     <= 1'b1;
            shdn_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            st_q     <= st_nxt;
            convst_q <= (st_nxt != ST_ACQ);
            rd_q     <= (st_nxt != ST_READ);
            cs_q     <= (st_nxt != ST_READ);
            shdn_q   <= (st_nxt == ST_SHDN);
            err_q    <= err_set;
        end
    end

    adc_wait_timer #(.W(TW), .INIT(WAKE_CYC - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_ld),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    adc_cnv_clkgen #(.HALF_CYC(CLK_HALF), .EDGE_W(EDGE_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (burst_go),
        .edges   (burst_edges),
        .cnv_clk (adc_clk),
        .done    (burst_done)
    );

    adc_code_fmt #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_fmt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cap),
        .bipolar (bipolar),
        .code    (adc_data),
        .sample  (sample),
        .valid   (sample_valid)
    );

    assign adc_convst  = convst_q;
    assign adc_rd_n    = rd_q;
    assign adc_cs_n    = cs_q;
    assign adc_shdn    = shdn_q;
    assign timeout_err = err_q;

    AST_CS_TRACKS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        adc_rd_n == adc_cs_n); // R6

    AST_CONVST_HIGH_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> adc_convst); // R4

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid); // R10

    AST_ERR_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (adc_rd_n && adc_convst && !sample_valid)); // R11

    AST_SHDN_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_shdn |-> (adc_convst && adc_rd_n)); // R12

    AST_NO_ACQ_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_rd_n) |=> adc_convst); // R7

endmodule

// File: tb/adc_seq_ctrl_bench.sv
// Directed bench: a converter model plus one task per scenario.
module adc_seq_ctrl_bench;
    localparam int P_WAKE  = 40;
    localparam int P_PINT  = 12;
    localparam int P_PEDG  = 20;
    localparam int P_CEDG  = 17;
    localparam int P_HALF  = 7;
    localparam int P_ACQ   = 8;
    localparam int P_RD    = 6;
    localparam int P_QUIET = 10;
    localparam int P_TOUT  = 400;
    localparam int INT_CONV = 320;
    localparam int EOC_LOW  = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_mode = 1'b1;
    logic bipolar = 1'b0;
    logic start_req = 1'b0;
    logic shutdown_req = 1'b0;
    logic adc_eoc_n;
    logic [13:0] adc_data;
    logic adc_convst, adc_cs_n, adc_rd_n, adc_clk, adc_shdn;
    logic [15:0] sample;
    logic sample_valid, timeout_err;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl #(
        .WAKE_CYC(P_WAKE), .PRIME_INT_CYC(P_PINT), .PRIME_EDGES(P_PEDG),
        .CONV_EDGES(P_CEDG), .CLK_HALF(P_HALF), .ACQ_CYC(P_ACQ),
        .RD_CYC(P_RD), .QUIET_CYC(P_QUIET), .TIMEOUT_CYC(P_TOUT)
    ) u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_clk_mode(ext_mode), .bipolar(bipolar),
        .start_req(start_req), .shutdown_req(shutdown_req),
        .adc_eoc_n(adc_eoc_n), .adc_data(adc_data),
        .adc_convst(adc_convst), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
        .adc_clk(adc_clk), .adc_shdn(adc_shdn), .sample(sample),
        .sample_valid(sample_valid), .timeout_err(timeout_err)
    );

    // ---------------- converter model ----------------
    logic [13:0] code_q = 14'h0;
    logic eoc_dis = 1'b0;
    logic m_cv_prev = 1'b1, m_ck_prev = 1'b0, m_busy = 1'b0;
    int m_dly = 0, m_edges = 0, m_low = 0, rd_cnt = 0;

    always @(posedge clk) begin
        logic fire;
        fire = 1'b0;
        m_cv_prev <= adc_convst;
        m_ck_prev <= adc_clk;
        if (adc_convst && !m_cv_prev) begin
            m_busy <= 1'b1; m_dly <= 0; m_edges <= 0;
        end else if (m_busy) begin
            if (!ext_mode) begin
                m_dly <= m_dly + 1;
                if (m_dly == INT_CONV - 1) fire = 1'b1;
            end else if (adc_clk && !m_ck_prev) begin
                m_edges <= m_edges + 1;
                if (m_edges == P_CEDG - 1) fire = 1'b1;
            end
        end
        if (fire) begin
            m_busy <= 1'b0;
            if (!eoc_dis) m_low <= EOC_LOW;
        end else if (m_low != 0) begin
            m_low <= m_low - 1;
        end
        if (!adc_rd_n && !adc_cs_n) rd_cnt <= rd_cnt + 1;
        else rd_cnt <= 0;
    end

    assign adc_eoc_n = (m_low == 0);
    assign adc_data  = (rd_cnt >= P_RD - 1) ? code_q : 14'h1555;

    // ---------------- pin monitor (negedge) ----------------
    logic p_cv = 1'b1, p_rd = 1'b1, p_ck = 1'b0, p_val = 1'b0;
    int cv_run = 0, last_acq = 0, rd_run = 0, last_rd = 0, ck_run = 0, last_ckh = 0;
    int clk_rises = 0, cv_falls = 0, rd_falls = 0, valid_cnt = 0;
    int since_rd = 0, last_gap = 0, conv_base = 0, csrd_mis = 0, cv_low_rd = 0;
    bit gap_arm = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_cv <= 1'b1; p_rd <= 1'b1; p_ck <= 1'b0; p_val <= 1'b0;
        end else begin
            p_cv <= adc_convst; p_rd <= adc_rd_n; p_ck <= adc_clk; p_val <= sample_valid;
            if (!adc_convst) cv_run <= cv_run + 1;
            if (adc_convst && !p_cv) begin last_acq <= cv_run; cv_run <= 0; conv_base <= clk_rises; end
            if (!adc_convst && p_cv) cv_falls <= cv_falls + 1;
            if (!adc_rd_n) rd_run <= rd_run + 1;
            if (adc_rd_n && !p_rd) begin last_rd <= rd_run; rd_run <= 0; end
            if (!adc_rd_n && p_rd) rd_falls <= rd_falls + 1;
            if (adc_clk) ck_run <= ck_run + 1;
            if (adc_clk && !p_ck) clk_rises <= clk_rises + 1;
            if (!adc_clk && p_ck) begin last_ckh <= ck_run; ck_run <= 0; end
            if (sample_valid && !p_val) valid_cnt <= valid_cnt + 1;
            if (adc_cs_n != adc_rd_n) csrd_mis <= csrd_mis + 1;
            if (!adc_rd_n && !adc_convst) cv_low_rd <= cv_low_rd + 1;
            if (adc_rd_n && !p_rd) begin since_rd <= 1; gap_arm <= 1'b1; end
            else if (gap_arm && adc_convst) since_rd <= since_rd + 1;
            else if (gap_arm && !adc_convst && p_cv) begin last_gap <= since_rd; gap_arm <= 1'b0; end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic pulse_start;
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    task automatic wait_valid(output bit got, output int s);
        got = 1'b0; s = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (sample_valid) begin got = 1'b1; s = int'($signed(sample)); break; end
        end
    endtask

    task automatic do_reset(input bit ext);
        rst_n = 1'b0; ext_mode = ext;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_prime(input bit ext);
        int base, f0;
        do_reset(ext);
        base = clk_rises; f0 = cv_falls;
        @(negedge clk);
        chk(adc_convst && adc_cs_n && adc_rd_n, "R1 idle pins", {adc_convst, adc_cs_n, adc_rd_n}, 7);
        chk(!adc_shdn && !sample_valid && !timeout_err, "R1 flags", {adc_shdn, sample_valid, timeout_err}, 0);
        repeat (5) @(negedge clk);
        pulse_start();
        repeat (ext ? 400 : 100) @(negedge clk);
        chk(cv_falls == f0, "R1 start ignored during wake", cv_falls - f0, 0);
        chk(clk_rises - base == (ext ? P_PEDG : 0), "R2 priming edges", clk_rises - base, ext ? P_PEDG : 0);
    endtask

    task automatic t_convert(input logic [13:0] code, input bit bip, input int exp, input string tag);
        bit got; int s;
        code_q = code; bipolar = bip;
        pulse_start();
        wait_valid(got, s);
        chk(got, "R10 valid seen", got, 1);
        chk(s == exp, tag, s, exp);
        @(negedge clk);
        chk(!sample_valid, "R10 one-cycle valid", sample_valid, 0);
        chk(last_acq == P_ACQ, "R3 acquisition length", last_acq, P_ACQ);
        chk(last_rd == P_RD, "R6 read length", last_rd, P_RD);
        chk(csrd_mis == 0, "R6 cs follows rd", csrd_mis, 0);
        chk(cv_low_rd == 0, "R4 convst high in read", cv_low_rd, 0);
        if (ext_mode) begin
            chk(clk_rises - conv_base == P_CEDG, "R5 burst edges", clk_rises - conv_base, P_CEDG);
            chk(last_ckh == P_HALF, "R5 high phase", last_ckh, P_HALF);
        end else begin
            chk(clk_rises == conv_base, "R5 clock idle in internal mode", clk_rises - conv_base, 0);
        end
        repeat (P_QUIET + 4) @(negedge clk);
    endtask

    task automatic t_quiet;
        bit got; int s; int f0;
        code_q = 14'h2abc; bipolar = 1'b1;
        @(negedge clk) start_req = 1'b1;
        wait_valid(got, s);
        f0 = cv_falls;
        for (int i = 0; i < 200 && cv_falls == f0; i++) @(negedge clk);
        start_req = 1'b0;
        @(negedge clk);
        chk(last_gap >= P_QUIET + 1, "R7 quiet gap", last_gap, P_QUIET + 1);
        wait_valid(got, s);
        chk(got && s == -5444, "R9 back-to-back sample", s, -5444);
        repeat (P_QUIET + 4) @(negedge clk);
    endtask

    task automatic t_busy;
        bit got; int s; int f0, v0;
        code_q = 14'h0100; bipolar = 1'b0;
        f0 = cv_falls; v0 = valid_cnt;
        pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();
        wait_valid(got, s);
        repeat (80) @(negedge clk);
        chk(cv_falls - f0 == 1, "R13 single acquisition", cv_falls - f0, 1);
        chk(valid_cnt - v0 == 1, "R13 single result", valid_cnt - v0, 1);
    endtask

    task automatic t_timeout;
        bit seen; int r0;
        eoc_dis = 1'b1; seen = 1'b0; r0 = rd_falls;
        pulse_start();
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (timeout_err) begin seen = 1'b1; break; end
        end
        chk(seen, "R11 timeout raised", seen, 1);
        @(negedge clk);
        chk(!timeout_err, "R11 one-cycle error", timeout_err, 0);
        chk(rd_falls == r0, "R11 no read", rd_falls - r0, 0);
        eoc_dis = 1'b0;
        repeat (5) @(negedge clk);
        t_convert(14'h3000, 1'b0, 4096, "R11 idle after timeout");
    endtask

    task automatic t_shutdown;
        int f0, base;
        @(negedge clk) shutdown_req = 1'b1;
        @(negedge clk);
        chk(adc_shdn, "R12 shutdown raised", adc_shdn, 1);
        f0 = cv_falls;
        pulse_start();
        repeat (20) @(negedge clk);
        chk(cv_falls == f0, "R12 no conversion in shutdown", cv_falls - f0, 0);
        base = clk_rises;
        shutdown_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!adc_shdn, "R12 shutdown released", adc_shdn, 0);
        pulse_start();
        repeat (400) @(negedge clk);
        chk(cv_falls == f0, "R12 start ignored during rewake", cv_falls - f0, 0);
        chk(clk_rises - base == P_PEDG, "R12 priming repeated", clk_rises - base, P_PEDG);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        t_reset_prime(1'b1);
        t_convert(14'h2000, 1'b0, 0, "R8 midscale");
        t_convert(14'h3fff, 1'b0, 8191, "R8 top code");
        t_convert(14'h0000, 1'b0, -8192, "R8 bottom code");
        t_convert(14'h2000, 1'b1, -8192, "R9 most negative");
        t_convert(14'h3fff, 1'b1, -1, "R9 minus one");
        t_convert(14'h1fff, 1'b1, 8191, "R9 most positive");
        t_quiet();
        t_busy();
        t_timeout();
        t_shutdown();
        t_convert(14'h0005, 1'b1, 5, "R12 convert after wake");
        t_reset_prime(1'b0);
        t_convert(14'h0001, 1'b1, 1, "R9 internal clock");
        t_convert(14'h2001, 1'b0, 1, "R8 internal clock");
        summary();
        $finish;
    end

endmodule